// File: doc/BRIEF.md
# Multiplexer Funnel and Ring Shifter

This block shifts a data word left by a binary amount from zero up to one less than the number of multiplexer inputs. It is purely combinational: every output bit is a single N-input multiplexer column whose select is the shift amount. No clock, register or sequencing controller is involved, so the result is valid in the same cycle as the inputs.

The low positions that a left shift vacates are not forced to zero. They are filled from a separate fill bus, so the block can act as a funnel that pulls bits in from a neighbouring word. A second group of duplicated columns above the word catches the bits that would fall off the top. The wide output therefore carries the whole shifted word without loss. When the wrap mode is selected, the fill bus is replaced internally by the word's own upper bits, and the narrow output becomes a left rotate.

With the defaults, the word is 4 bits wide, the multiplexers have 4 inputs, the shift amount is 2 bits and the fill bus is 3 bits. The multiplexer input count N must not exceed the word width plus one.

Top module: `shift_mux_funnel`

## Requirements
- R1: For every output position i with i >= shamt, `trunc_out[i]` equals `data_in[i - shamt]`.
- R2: With `wrap_en` = 0 and i < shamt, `trunc_out[i]` equals `fill_in[shamt - i - 1]`. `fill_in[0]` is the bit directly below `data_in[0]`, and `fill_in[1]` is the bit below that.
- R3: With `shamt` = 0, `trunc_out` equals `data_in` and the upper part of `wide_out` (bits W and above) is all zero, in either mode.
- R4: The low W bits of `wide_out` are always equal to `trunc_out`.
- R5: For each k with 0 <= k < N-1, `wide_out[W + k]` equals `data_in[W + k - shamt]` when that index lies in the word, and 0 otherwise. No data bit shifted past the top of the word is lost.
- R6: With `wrap_en` = 0 and `fill_in` all zero, `wide_out` equals `data_in` zero-extended to W+N-1 bits and shifted left by `shamt`.
- R7: With `wrap_en` = 1, `trunc_out` is `data_in` rotated left by `shamt`. The fill bus has no effect: internally fill bit k is taken from `data_in[W-1-k]`.
- R8: With `wrap_en` = 1, `trunc_out` has the same number of ones as `data_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | W | Word to be shifted |
| fill_in | input | N-1 | Bits entering the vacated low positions; bit 0 is nearest the word |
| shamt | input | clog2(N) | Left shift amount, 0 to N-1 |
| wrap_en | input | 1 | 1 selects rotate: fill taken from the word's own upper bits |
| trunc_out | output | W | Shifted word, truncated to W bits |
| wide_out | output | W+N-1 | Shifted word including the bits carried out above the top |

## Verification
The embedded assertions check four things on every input change. A zero shift passes the word straight through. With an all-zero fill, the wide output is a plain lossless left shift. In wrap mode, the narrow output matches a rotate and keeps the word's count of ones. The bit-by-bit routing of individual fill bits into the vacated positions (R2) is shown only by the bench's exhaustive scenarios. The same holds for the placement of carried-out bits in the upper columns when the fill is non-zero, for the agreement of the two outputs' shared low bits, and for the fill bus having no effect in wrap mode.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic {
    FILL_EXTERNAL = 1'b0,
    FILL_WRAP     = 1'b1
  } fill_mode_e;

  // Position in the source window read by output column `col` at shift `s`.
  // The window holds (n-1) fill bits below the word, so index 0 is the
  // deepest fill bit.
  function automatic int tap_index(input int col, input int s, input int n);
    return col - s + (n - 1);
  endfunction

  // Rotate-left of the low `w` bits of `v` by `k` places.
  function automatic logic [63:0] rotl_word(input logic [63:0] v,
                                            input int w, input int k);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < w; i++) begin
      r[(i + k) % w] = v[i];
    end
    return r;
  endfunction

  // Number of set bits among the low `w` bits of `v`.
  function automatic int ones_in(input logic [63:0] v, input int w);
    int c;
    c = 0;
    for (int i = 0; i < w; i++) begin
      c += int'(v[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/shf_mux_column.sv
module shf_mux_column #(
  parameter  int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  taps,
  input  logic [SW-1:0] sel,
  output logic          bit_out
);

  generate
    if (N == (1 << SW)) begin : g_full
      // Every select code names a tap.
      assign bit_out = taps[sel];
    end else begin : g_partial
      // Codes beyond N-1 select nothing and give zero.
      always_comb begin
        bit_out = 1'b0;
        for (int s = 0; s < N; s++) begin
          if (sel == SW'(s)) bit_out = taps[s];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/shf_slice.sv
module shf_slice #(
  parameter  int COLS = 4,
  parameter  int N    = 4,
  localparam int SW   = (N > 1) ? $clog2(N) : 1,
  localparam int WINW = COLS + N - 1
) (
  input  logic [WINW-1:0] win,
  input  logic [SW-1:0]   sel,
  output logic [COLS-1:0] cols_out
);
  import shf_pkg::*;

  logic [N-1:0] taps [COLS];

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar s = 0; s < N; s++) begin : g_tap
        localparam int IDX = tap_index(c, s, N);
        assign taps[c][s] = win[IDX];
      end
      shf_mux_column #(.N(N)) u_col (
        .taps    (taps[c]),
        .sel     (sel),
        .bit_out (cols_out[c])
      );
    end
  endgenerate

endmodule

// File: rtl/shf_fill_route.sv
module shf_fill_route #(
  parameter  int W  = 4,
  parameter  int N  = 4,
  localparam int FW = N - 1
) (
  input  logic [W-1:0]        data_in,
  input  logic [FW-1:0]       fill_in,
  input  shf_pkg::fill_mode_e mode,
  output logic [FW-1:0]       fill_eff
);
  import shf_pkg::*;

  generate
    for (genvar k = 0; k < FW; k++) begin : g_fill
      // In wrap mode, fill bit k (position -(k+1)) mirrors word bit W-1-k.
      assign fill_eff[k] = (mode == FILL_WRAP) ? data_in[W-1-k] : fill_in[k];
    end
  endgenerate

endmodule

// File: rtl/shift_mux_funnel.sv
module shift_mux_funnel #(
  parameter  int W    = 4,
  parameter  int N    = 4,
  localparam int SW   = (N > 1) ? $clog2(N) : 1,
  localparam int FW   = N - 1,
  localparam int WW   = W + N - 1,
  localparam int SRCW = W + 2 * FW
) (
  input  logic [W-1:0]  data_in,
  input  logic [FW-1:0] fill_in,
  input  logic [SW-1:0] shamt,
  input  logic          wrap_en,
  output logic [W-1:0]  trunc_out,
  output logic [WW-1:0] wide_out
);
  import shf_pkg::*;

  fill_mode_e    mode;
  logic [FW-1:0] fill_eff;
  logic [SRCW-1:0] src_vec;
  logic [W-1:0]  lo_cols;
  logic [FW-1:0] hi_cols;

  // Named events for the checks below.
  logic ring_active;
  logic shift_idle;
  logic fill_quiet;
  logic inputs_known;

  assign mode         = wrap_en ? FILL_WRAP : FILL_EXTERNAL;
  assign ring_active  = (mode == FILL_WRAP);
  assign shift_idle   = (shamt == '0);
  assign fill_quiet   = (fill_in == '0);
  assign inputs_known = !$isunknown({data_in, fill_in, shamt, wrap_en});

  shf_fill_route #(.W(W), .N(N)) u_fill (
    .data_in  (data_in),
    .fill_in  (fill_in),
    .mode     (mode),
    .fill_eff (fill_eff)
  );

  // Source window: zero pad on top, then the word, then the fill bits,
  // with fill bit 0 directly under the word's bit 0.
  assign src_vec[SRCW-1:FW+W] = '0;
  assign src_vec[FW+W-1:FW]   = data_in;
  generate
    for (genvar k = 0; k < FW; k++) begin : g_src_fill
      assign src_vec[FW-1-k] = fill_eff[k];
    end
  endgenerate

  // Columns for the word positions.
  shf_slice #(.COLS(W), .N(N)) u_lo (
    .win      (src_vec[W+FW-1:0]),
    .sel      (shamt),
    .cols_out (lo_cols)
  );

  // Duplicate columns that catch bits carried past the top.
  shf_slice #(.COLS(FW), .N(N)) u_hi (
    .win      (src_vec[SRCW-1:W]),
    .sel      (shamt),
    .cols_out (hi_cols)
  );

  assign trunc_out = lo_cols;
  assign wide_out  = {hi_cols, lo_cols};

  always_comb begin
    if (inputs_known) begin
      if (shift_idle) begin
        AST_ZERO_SHIFT_PASS: assert (trunc_out == data_in && wide_out[WW-1:W] == '0); // R3
      end
      if (!ring_active && fill_quiet) begin
        AST_LOSSLESS_WIDE: assert (wide_out == (WW'(data_in) << shamt)); // R6
      end
      if (ring_active) begin
        AST_RING_ROTATE: assert (64'(trunc_out) == rotl_word(64'(data_in), W, int'(shamt))); // R7
        AST_RING_ONES_KEPT: assert (ones_in(64'(trunc_out), W) == ones_in(64'(data_in), W)); // R8
      end
    end
  end

endmodule

// File: tb/tb_shift_mux_funnel.sv
module tb_shift_mux_funnel;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int N  = 4;
  localparam int FW = 3;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0]  data_in = '0;
  logic [FW-1:0] fill_in = '0;
  logic [1:0]    shamt   = '0;
  logic          wrap_en = 1'b0;
  logic [W-1:0]  trunc_out;
  logic [WW-1:0] wide_out;

  shift_mux_funnel dut (
    .data_in   (data_in),
    .fill_in   (fill_in),
    .shamt     (shamt),
    .wrap_en   (wrap_en),
    .trunc_out (trunc_out),
    .wide_out  (wide_out)
  );

  typedef struct {
    logic [W-1:0]  ey;
    logic [WW-1:0] ew;
    logic [W-1:0]  xin;
    logic          ring;
    string         ty;
    string         tw;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference: concatenate word over fill, shift, take a window.
  function automatic exp_t model(input logic [W-1:0] x, input logic [FW-1:0] e,
                                 input logic [1:0] s, input logic r);
    exp_t m;
    logic [9:0] v;
    logic [7:0] rr;
    logic [6:0] xw;
    m.xin  = x;
    m.ring = r;
    if (r) begin
      rr   = {x, x} << s;           // R7 rotate reference
      m.ey = rr[7:4];
      m.ty = "R7";
    end else begin
      v    = {3'b000, x, e[0], e[1], e[2]} << s;
      m.ey = v[6:3];
      m.ty = (s == 2'd0) ? "R3" : "R1/R2";
    end
    xw   = {3'b000, x} << s;
    m.ew = {xw[6:4], m.ey};
    m.tw = (!r && e == '0) ? "R6" : "R5";
    return m;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [FW-1:0] e,
                       input logic [1:0] s, input logic r);
    @(posedge clk);
    #1;
    data_in = x;
    fill_in = e;
    shamt   = s;
    wrap_en = r;
    q.push_back(model(x, e, s, r));
  endtask

  // Monitor: results are combinational, sampled at the following negedge.
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(trunc_out == it.ey, it.ty, "trunc_out", 32'(trunc_out), 32'(it.ey));
      chk(wide_out == it.ew, it.tw, "wide_out", 32'(wide_out), 32'(it.ew));
      chk(wide_out[W-1:0] == trunc_out, "R4", "wide low bits",
          32'(wide_out[W-1:0]), 32'(trunc_out));
      if (it.ring) begin
        chk($countones(trunc_out) == $countones(it.xin), "R8", "ones count",
            32'($countones(trunc_out)), 32'($countones(it.xin)));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // Reset-like state: all-zero inputs give all-zero outputs (R3).
    drive(4'h0, 3'h0, 2'd0, 1'b0);
    // R2: single fill bits walk into vacated positions.
    drive(4'h0, 3'b001, 2'd1, 1'b0);
    drive(4'h0, 3'b010, 2'd2, 1'b0);
    drive(4'h0, 3'b100, 2'd3, 1'b0);
    // R7: fill bus ignored in wrap mode, same expected result.
    drive(4'b1001, 3'b000, 2'd2, 1'b1);
    drive(4'b1001, 3'b111, 2'd2, 1'b1);
    // R5: top bit carried into the widest column.
    drive(4'b1000, 3'b111, 2'd3, 1'b0);
    // Exhaustive sweep of every input combination (R1 R6 R8).
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) begin
        for (int x = 0; x < 16; x++) begin
          for (int e = 0; e < 8; e++) begin
            drive(4'(x), 3'(e), 2'(s), 1'(r));
          end
        end
      end
    end
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule